// File: doc/BRIEF.md
# OLED Tile-Draw Command Sequencer

This block turns a single request into the ordered byte stream that a greyscale OLED controller expects. A request is one of four kinds: draw, panel on, panel off or contrast level. A draw request sets a row window that spans the eight pixel rows of one tile row. It then writes each tile. Every tile gets its own four-column window, followed by the 32 expanded data bytes of that tile. The data bytes come from an external tile expander through a valid/ready handshake. The sequencer reports which tile of the run it needs on `tile_pos`.

Each output byte carries a flag that separates controller commands and their arguments from display data. The whole transfer for one request is framed by an active-low select. The byte stream is meant to feed a serial or parallel shifter that sits outside this block. While a frame is in progress the sequencer reports busy and ignores any further request.

Top module: `oled_tile_seq`

## Requirements
- R1: `cs_n` is high when idle. It goes low one cycle before the first byte of a request and returns high one cycle after the last byte. No byte is presented while `cs_n` is high.
- R2: A draw request (`req_kind` = 0) first emits command 0x75, then tile_y*8, then tile_y*8+7.
- R3: The first column window of a draw is command 0x15 followed by c and c+3. Here c = tile_x*4 + floor(offset/2), taken modulo 256.
- R4: After each column window the block emits exactly 32 data bytes with `out_dc`=1. Each byte is taken unchanged from `data_byte` on a cycle where `data_valid` and `data_ready` are both high. `tile_pos` gives the position of the tile within the run, starting at 0.
- R5: The column start grows by 4 after every tile, and it keeps growing across repetitions.
- R6: The run of `req_tile_cnt` tiles is sent `req_repeat` times. `tile_pos` restarts at 0 at the start of each repetition.
- R7: A tile count or repeat count of zero behaves as one.
- R8: A panel-on request (`req_kind` = 1) emits only 0xAF, and a panel-off request (`req_kind` = 2) emits only 0xAE. Each is sent in a frame of its own.
- R9: A contrast request (`req_kind` = 3) emits 0x81 followed by `req_level`, for any value from 0 to 255.
- R10: `busy` is high from the cycle after a request is accepted until `cs_n` has returned high. A request presented while `busy` is high has no effect.
- R11: Every command and argument byte carries `out_dc`=0.
- R12: While `data_valid` is low during a tile, no byte is presented and the sequence waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 2 | 0 draw, 1 panel on, 2 panel off, 3 contrast |
| req_tile_x | input | TX_W | Tile column of the first tile |
| req_tile_y | input | TY_W | Tile row |
| req_tile_cnt | input | CNT_W | Tiles per run (0 means 1) |
| req_repeat | input | REP_W | Number of runs (0 means 1) |
| req_offset | input | OFS_W | Horizontal pixel offset |
| req_level | input | 8 | Contrast level argument |
| busy | output | 1 | Frame in progress |
| tile_pos | output | CNT_W | Tile index within the run, for the expander |
| data_ready | output | 1 | Sequencer takes a data byte |
| data_valid | input | 1 | Expander offers a data byte |
| data_byte | input | 8 | Expanded tile byte |
| cs_n | output | 1 | Active-low frame select |
| out_valid | output | 1 | A byte is presented this cycle |
| out_dc | output | 1 | 0 command/argument, 1 display data |
| out_byte | output | 8 | Output byte |

## Verification
On every cycle, the embedded properties check four things: bytes appear only inside a frame, the frame opens with a silent cycle, busy covers the whole frame, and a data byte is only shown when the expander offers one. Further properties check that the column start steps by four per finished tile and that the tile position wraps to zero only when a repetition ends. The exact order of opcodes, window arguments and data bytes can only be shown by the bench scenarios. These include the repeated multi-tile run, the halved offset, the zero-count case, stalls from the expander and a request dropped while busy.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

   typedef enum logic [1:0] {
      KIND_DRAW  = 2'd0,
      KIND_ON    = 2'd1,
      KIND_OFF   = 2'd2,
      KIND_LEVEL = 2'd3
   } req_kind_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OPEN,
      ST_ROW_OP,
      ST_ROW_LO,
      ST_ROW_HI,
      ST_COL_OP,
      ST_COL_LO,
      ST_COL_HI,
      ST_DATA,
      ST_SOLO_OP,
      ST_SOLO_ARG,
      ST_CLOSE
   } seq_state_t;

   localparam logic [7:0] OP_ROW_WIN   = 8'h75;
   localparam logic [7:0] OP_COL_WIN   = 8'h15;
   localparam logic [7:0] OP_PANEL_ON  = 8'hAF;
   localparam logic [7:0] OP_PANEL_OFF = 8'hAE;
   localparam logic [7:0] OP_LEVEL     = 8'h81;

   typedef struct packed {
      logic       dc;
      logic [7:0] val;
   } out_beat_t;

endpackage

// File: rtl/oled_seq_window.sv
module oled_seq_window #(
   parameter int TX_W  = 5,
   parameter int TY_W  = 4,
   parameter int OFS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [TX_W-1:0]  tile_x,
   input  logic [TY_W-1:0]  tile_y,
   input  logic [OFS_W-1:0] offset,
   output logic [7:0]       row_lo,
   output logic [7:0]       row_hi,
   output logic [7:0]       col_lo,
   output logic [7:0]       col_hi
);
   localparam int COL_STEP = 4;
   localparam int ROW_SPAN = 8;

   logic [7:0] half_ofs;
   logic [7:0] col_first;
   logic [7:0] row_first;
   logic [7:0] row_q;
   logic [7:0] col_q;

   generate
      if (OFS_W > 1) begin : g_half
         assign half_ofs = 8'(offset >> 1);
      end else begin : g_nohalf
         assign half_ofs = 8'd0;
      end
   endgenerate

   assign col_first = 8'(tile_x) * 8'(COL_STEP) + half_ofs;
   assign row_first = 8'(tile_y) * 8'(ROW_SPAN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else if (load) begin
         row_q <= row_first;
         col_q <= col_first;
      end else if (step) begin
         col_q <= col_q + 8'(COL_STEP);
      end
   end

   assign row_lo = row_q;
   assign row_hi = row_q + 8'(ROW_SPAN - 1);
   assign col_lo = col_q;
   assign col_hi = col_q + 8'(COL_STEP - 1);

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> col_lo == $past(col_lo) + 8'd4); // R5

endmodule

// File: rtl/oled_seq_counts.sv
module oled_seq_counts #(
   parameter int CNT_W = 5,
   parameter int REP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             tile_done,
   input  logic [CNT_W-1:0] cnt,
   input  logic [REP_W-1:0] rep,
   output logic [CNT_W-1:0] tile_pos,
   output logic             last_tile,
   output logic             last_pass
);
   logic [CNT_W-1:0] cnt_m1_q;
   logic [REP_W-1:0] rep_m1_q;
   logic [CNT_W-1:0] pos_q;
   logic [REP_W-1:0] pass_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_m1_q <= '0;
         rep_m1_q <= '0;
         pos_q    <= '0;
         pass_q   <= '0;
      end else if (load) begin
         cnt_m1_q <= (cnt == '0) ? '0 : cnt - 1'b1;
         rep_m1_q <= (rep == '0) ? '0 : rep - 1'b1;
         pos_q    <= '0;
         pass_q   <= '0;
      end else if (tile_done) begin
         if (pos_q == cnt_m1_q) begin
            pos_q  <= '0;
            pass_q <= pass_q + 1'b1;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   assign tile_pos  = pos_q;
   assign last_tile = (pos_q == cnt_m1_q);
   assign last_pass = (pass_q == rep_m1_q);

   AST_TILE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !load |-> pos_q <= cnt_m1_q); // R6
   AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tile_done && last_tile && !load) |=> tile_pos == '0); // R6

endmodule

// File: rtl/oled_seq_ctrl.sv
module oled_seq_ctrl
   import oled_seq_pkg::*;
#(
   parameter int BEATS = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [1:0] req_kind,
   input  logic [7:0] req_level,
   input  logic       last_tile,
   input  logic       last_pass,
   input  logic       data_valid,
   input  logic [7:0] data_byte,
   input  logic [7:0] row_lo,
   input  logic [7:0] row_hi,
   input  logic [7:0] col_lo,
   input  logic [7:0] col_hi,
   output logic       load,
   output logic       tile_done,
   output logic       busy,
   output logic       cs_n,
   output logic       data_ready,
   output logic       out_valid,
   output logic       out_dc,
   output logic [7:0] out_byte
);
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

   seq_state_t        state_q, state_d;
   req_kind_t         kind_q;
   logic [7:0]        level_q;
   logic [BEAT_W-1:0] beat_q;
   out_beat_t         beat;
   logic              accept;
   logic              fire;

   assign accept = (state_q == ST_IDLE) && req_valid;
   assign fire   = (state_q == ST_DATA) && data_valid;
   assign tile_done = fire && (beat_q == LAST_BEAT);
   assign load   = accept && (req_kind_t'(req_kind) == KIND_DRAW);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (accept) state_d = ST_OPEN;
         ST_OPEN:     state_d = (kind_q == KIND_DRAW) ? ST_ROW_OP : ST_SOLO_OP;
         ST_ROW_OP:   state_d = ST_ROW_LO;
         ST_ROW_LO:   state_d = ST_ROW_HI;
         ST_ROW_HI:   state_d = ST_COL_OP;
         ST_COL_OP:   state_d = ST_COL_LO;
         ST_COL_LO:   state_d = ST_COL_HI;
         ST_COL_HI:   state_d = ST_DATA;
         ST_DATA:     if (tile_done)
                         state_d = (last_tile && last_pass) ? ST_CLOSE : ST_COL_OP;
         ST_SOLO_OP:  state_d = (kind_q == KIND_LEVEL) ? ST_SOLO_ARG : ST_CLOSE;
         ST_SOLO_ARG: state_d = ST_CLOSE;
         ST_CLOSE:    state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= KIND_DRAW;
         level_q <= '0;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            kind_q  <= req_kind_t'(req_kind);
            level_q <= req_level;
         end
         if (fire) beat_q <= (beat_q == LAST_BEAT) ? '0 : beat_q + 1'b1;
      end
   end

   always_comb begin
      beat      = '{dc: 1'b0, val: 8'h00};
      out_valid = 1'b1;
      unique case (state_q)
         ST_ROW_OP:   beat.val = OP_ROW_WIN;
         ST_ROW_LO:   beat.val = row_lo;
         ST_ROW_HI:   beat.val = row_hi;
         ST_COL_OP:   beat.val = OP_COL_WIN;
         ST_COL_LO:   beat.val = col_lo;
         ST_COL_HI:   beat.val = col_hi;
         ST_DATA: begin
            beat      = '{dc: 1'b1, val: data_byte};
            out_valid = data_valid;
         end
         ST_SOLO_OP: begin
            unique case (kind_q)
               KIND_ON:  beat.val = OP_PANEL_ON;
               KIND_OFF: beat.val = OP_PANEL_OFF;
               default:  beat.val = OP_LEVEL;
            endcase
         end
         ST_SOLO_ARG: beat.val = level_q;
         default:     out_valid = 1'b0;
      endcase
   end

   assign out_dc     = beat.dc;
   assign out_byte   = beat.val;
   assign data_ready = (state_q == ST_DATA);
   assign busy       = (state_q != ST_IDLE);
   assign cs_n       = (state_q == ST_IDLE);

   AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !cs_n); // R1
   AST_OPEN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !out_valid); // R1
   AST_BUSY_COVERS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy); // R10
   AST_DATA_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_dc) |-> (data_valid && data_ready)); // R12

endmodule

// File: rtl/oled_tile_seq.sv
module oled_tile_seq #(
   parameter int TX_W  = 5,
   parameter int TY_W  = 4,
   parameter int CNT_W = 5,
   parameter int REP_W = 4,
   parameter int OFS_W = 6,
   parameter int BEATS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [1:0]       req_kind,
   input  logic [TX_W-1:0]  req_tile_x,
   input  logic [TY_W-1:0]  req_tile_y,
   input  logic [CNT_W-1:0] req_tile_cnt,
   input  logic [REP_W-1:0] req_repeat,
   input  logic [OFS_W-1:0] req_offset,
   input  logic [7:0]       req_level,
   output logic             busy,
   output logic [CNT_W-1:0] tile_pos,
   output logic             data_ready,
   input  logic             data_valid,
   input  logic [7:0]       data_byte,
   output logic             cs_n,
   output logic             out_valid,
   output logic             out_dc,
   output logic [7:0]       out_byte
);
   generate
      if (TX_W < 1 || TX_W > 6) begin : g_bad_tx
         $error("TX_W must be 1..6 so tile_x*4 fits a column byte");
      end
      if (TY_W < 1 || TY_W > 5) begin : g_bad_ty
         $error("TY_W must be 1..5 so tile_y*8 fits a row byte");
      end
      if (OFS_W < 1 || OFS_W > 9) begin : g_bad_ofs
         $error("OFS_W must be 1..9");
      end
      if (CNT_W < 1 || REP_W < 1) begin : g_bad_cnt
         $error("count widths must be positive");
      end
      if (BEATS < 2) begin : g_bad_beats
         $error("BEATS must be at least 2");
      end
   endgenerate

   logic       load;
   logic       tile_done;
   logic       last_tile;
   logic       last_pass;
   logic [7:0] row_lo, row_hi, col_lo, col_hi;

   oled_seq_window #(.TX_W(TX_W), .TY_W(TY_W), .OFS_W(OFS_W)) win_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (tile_done),
      .tile_x (req_tile_x),
      .tile_y (req_tile_y),
      .offset (req_offset),
      .row_lo (row_lo),
      .row_hi (row_hi),
      .col_lo (col_lo),
      .col_hi (col_hi)
   );

   oled_seq_counts #(.CNT_W(CNT_W), .REP_W(REP_W)) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .tile_done (tile_done),
      .cnt       (req_tile_cnt),
      .rep       (req_repeat),
      .tile_pos  (tile_pos),
      .last_tile (last_tile),
      .last_pass (last_pass)
   );

   oled_seq_ctrl #(.BEATS(BEATS)) ctl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_kind   (req_kind),
      .req_level  (req_level),
      .last_tile  (last_tile),
      .last_pass  (last_pass),
      .data_valid (data_valid),
      .data_byte  (data_byte),
      .row_lo     (row_lo),
      .row_hi     (row_hi),
      .col_lo     (col_lo),
      .col_hi     (col_hi),
      .load       (load),
      .tile_done  (tile_done),
      .busy       (busy),
      .cs_n       (cs_n),
      .data_ready (data_ready),
      .out_valid  (out_valid),
      .out_dc     (out_dc),
      .out_byte   (out_byte)
   );

endmodule

// File: tb/oled_tile_seq_tb.sv
module oled_tile_seq_tb_top;
   localparam int TX_W = 5, TY_W = 4, CNT_W = 5, REP_W = 4, OFS_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_kind = '0;
   logic [TX_W-1:0] req_tile_x = '0;
   logic [TY_W-1:0] req_tile_y = '0;
   logic [CNT_W-1:0] req_tile_cnt = '0;
   logic [REP_W-1:0] req_repeat = '0;
   logic [OFS_W-1:0] req_offset = '0;
   logic [7:0] req_level = '0;
   logic busy, data_ready, data_valid, cs_n, out_valid, out_dc;
   logic [CNT_W-1:0] tile_pos;
   logic [7:0] data_byte, out_byte;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit stall_en = 1'b0;
   logic [4:0] k_q;
   logic [8:0] expq[$];

   always #5 clk = ~clk;

   oled_tile_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_tile_x(req_tile_x), .req_tile_y(req_tile_y), .req_tile_cnt(req_tile_cnt),
      .req_repeat(req_repeat), .req_offset(req_offset), .req_level(req_level),
      .busy(busy), .tile_pos(tile_pos), .data_ready(data_ready),
      .data_valid(data_valid), .data_byte(data_byte), .cs_n(cs_n),
      .out_valid(out_valid), .out_dc(out_dc), .out_byte(out_byte)
   );

   function automatic logic [7:0] tile_data(input int t, input int k);
      return {3'(t), 5'(k)} ^ 8'hA5;
   endfunction

   // expander model
   assign data_valid = stall_en ? ((cyc % 3) != 2) : 1'b1;
   assign data_byte  = tile_data(int'(tile_pos), int'(k_q));
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) k_q <= '0;
      else if (data_valid && data_ready) k_q <= k_q + 1'b1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference comparison on every clock
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (expq.size() == 0) begin
            check(1'b0, "R10 unexpected byte", {out_dc, out_byte}, 0);
         end else begin
            logic [8:0] e;
            e = expq.pop_front();
            check({out_dc, out_byte} == e,
                  e[8] ? "R4 data byte" : "R11 command byte", {out_dc, out_byte}, e);
            check(!cs_n, "R1 byte inside frame", cs_n, 0);
         end
      end
   end

   task automatic push_cmd(input int v);
      expq.push_back({1'b0, 8'(v)});
   endtask

   task automatic model_draw(input int x, input int y, input int cnt, input int rep, input int ofs);
      int n = (cnt == 0) ? 1 : cnt;   // R7
      int r = (rep == 0) ? 1 : rep;
      int c = x * 4 + ofs / 2;
      push_cmd(8'h75); push_cmd(y * 8); push_cmd(y * 8 + 7);   // R2
      for (int p = 0; p < r; p++) begin                        // R6
         for (int t = 0; t < n; t++) begin
            push_cmd(8'h15); push_cmd(c & 255); push_cmd((c + 3) & 255);  // R3
            for (int k = 0; k < 32; k++) expq.push_back({1'b1, tile_data(t, k)});
            c += 4;                                            // R5
         end
      end
   endtask

   task automatic issue(input int kind, input int x, input int y, input int cnt,
                        input int rep, input int ofs, input int lvl);
      @(negedge clk);
      while (busy) @(negedge clk);
      req_kind = 2'(kind); req_tile_x = TX_W'(x); req_tile_y = TY_W'(y);
      req_tile_cnt = CNT_W'(cnt); req_repeat = REP_W'(rep);
      req_offset = OFS_W'(ofs); req_level = 8'(lvl);
      req_valid = 1'b1;
      check(cs_n, "R1 idle select high", cs_n, 1);
      @(negedge clk);
      req_valid = 1'b0;
      check(busy, "R10 busy after accept", busy, 1);
      check(!cs_n && !out_valid, "R1 select opens before first byte", {cs_n, out_valid}, 0);
   endtask

   task automatic finish_req(input string req);
      while (busy) @(negedge clk);
      check(expq.size() == 0, req, expq.size(), 0);
      check(cs_n, "R1 select released", cs_n, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n && !busy && !out_valid, "R1 reset state", {cs_n, busy, out_valid}, 3'b100);
      rst_n = 1'b1;

      push_cmd(8'hAF); issue(1, 0, 0, 0, 0, 0, 0); finish_req("R8 panel on");
      push_cmd(8'hAE); issue(2, 0, 0, 0, 0, 0, 0); finish_req("R8 panel off");
      push_cmd(8'h81); push_cmd(8'h00); issue(3, 0, 0, 0, 0, 0, 8'h00); finish_req("R9 contrast 0");
      push_cmd(8'h81); push_cmd(8'hFF); issue(3, 0, 0, 0, 0, 0, 8'hFF); finish_req("R9 contrast 255");

      model_draw(2, 3, 1, 1, 16); issue(0, 2, 3, 1, 1, 16, 0); finish_req("R2 single tile");

      stall_en = 1'b1;   // R12
      model_draw(1, 0, 3, 2, 5); issue(0, 1, 0, 3, 2, 5, 0); finish_req("R6 three tiles twice");

      stall_en = 1'b0;
      model_draw(31, 15, 0, 0, 63); issue(0, 31, 15, 0, 0, 63, 0); finish_req("R7 zero counts");

      // R10: a panel-on request during a draw must vanish
      model_draw(4, 1, 2, 1, 1); issue(0, 4, 1, 2, 1, 1, 0);
      repeat (10) @(negedge clk);
      req_kind = 2'd1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      finish_req("R10 request while busy");
      repeat (5) @(negedge clk);
      check(expq.size() == 0 && cs_n && !busy, "R10 no late frame", busy, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule